// File: doc/BRIEF.md
# Line Select Sequencer with Windowing and Decimation

This block drives the select lines that pick one row, or one column, of a pixel array at a time. A binary line address is held in a counter and decoded into a one-hot select vector. Because the address is held in a counter rather than passed down a shift chain, the same block can do four things:

- scan every line;
- scan a contiguous window;
- jump straight to a single line;
- visit every 2^k-th line of a window, which gives power-of-two subsampling.

A controller picks the scan kind, sets the bounds and pulses `start`. It then pulses `step` once per line time. The block raises `eos` while the final line of the scan is selected, and the next step returns it to idle with all selects low.

The block has no streaming data path. All pins are plain control and status levels, sampled on the rising clock edge. Because there is no valid/ready pair, there is no back-pressure. The controller simply withholds `step` for as long as it needs the current line held.

Top module: `scan_line_sequencer`

## Requirements
- R1: While `rst_n` is low, and at the first sample after it is released, `busy` is 0, `eos` is 0, `sel` is all zeros and `addr` is 0.
- R2: A `start` sampled while idle makes the block busy on the next cycle, at the first line of the chosen scan. At that edge it captures `scan_kind`, `win_lo`, `win_hi`, `pick_addr` and `decim_exp`. Changes to these inputs during a scan have no effect. A `start` sampled while busy is ignored.
- R3: While busy, exactly one bit of `sel` is 1, and its index equals `addr`. While idle, `sel` is all zeros.
- R4: When `scan_kind` = 0 (full), the scan visits every address from 0 to 2^ADDR_W-1 in ascending order, one address per step.
- R5: When `scan_kind` = 1 (window), the scan visits every address from `win_lo` to `win_hi` in ascending order, one address per step. If `win_lo` > `win_hi`, only `win_lo` is visited.
- R6: When `scan_kind` = 2 (single), only `pick_addr` is visited. `eos` is 1 from the first busy cycle onwards.
- R7: When `scan_kind` = 3 (decimated), the scan starts at `win_lo` and adds 2^`decim_exp` on each step. It stops at the last address that does not exceed the window end. If `win_lo` > `win_hi`, only `win_lo` is visited.
- R8: `eos` is 1 exactly while the last line of the scan is selected. A step taken in that state returns the block to idle on the next cycle.
- R9: While busy, `addr` holds its value in any cycle without `step`. A `step` sampled while idle has no effect.
- R10: If `start` and `step` are both sampled while idle, `start` is taken and `step` is dropped, so the first line of the scan is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scan when idle |
| step | input | 1 | Advance to the next line of the scan |
| scan_kind | input | 2 | 0 full, 1 window, 2 single, 3 decimated |
| win_lo | input | ADDR_W | Window first address |
| win_hi | input | ADDR_W | Window last address |
| pick_addr | input | ADDR_W | Address for a single-line scan |
| decim_exp | input | EXP_W | Decimation exponent k; the stride is 2^k |
| sel | output | 2^ADDR_W | One-hot line select |
| addr | output | ADDR_W | Binary address of the selected line |
| busy | output | 1 | A scan is in progress |
| eos | output | 1 | The last line of the scan is selected |

## Verification
There are two collisions that can happen in the same clock edge.

The first is `start` and `step` arriving together while the block is idle. The bench raises both for one cycle and checks that the selected line is the window start rather than the line after it.

The second is `start` arriving while a window scan is already busy. The bench raises `start` with the bounds and kind changed, and checks that `addr` stays where it was and the scan completes on its original bounds.

Every scan in every sweep also scrambles the configuration inputs right after its start, so the captured settings are checked on every line.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    KIND_FULL    = 2'd0,
    KIND_WINDOW  = 2'd1,
    KIND_SINGLE  = 2'd2,
    KIND_DECIM   = 2'd3
  } scan_kind_e;
endpackage

// File: rtl/scan_bounds_resolve.sv
// Turns the scan request into first address, last address and stride.
module scan_bounds_resolve
  import scan_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int EXP_W  = 3
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  input  logic [ADDR_W-1:0] pick,
  input  logic [EXP_W-1:0]  expo,
  output logic [ADDR_W-1:0] first,
  output logic [ADDR_W-1:0] last,
  output logic [ADDR_W:0]   stride
);
  localparam logic [ADDR_W-1:0] TOP_ADDR = {ADDR_W{1'b1}};

  scan_kind_e             kind_e;
  logic [ADDR_W-1:0]      hi_eff;
  logic [ADDR_W:0]        decim_stride;

  assign kind_e = scan_kind_e'(kind);
  // An inverted window collapses to its start line.
  assign hi_eff = (hi < lo) ? lo : hi;

  always_comb begin
    if (int'(expo) >= ADDR_W) decim_stride = {1'b1, {ADDR_W{1'b0}}};
    else                      decim_stride = (ADDR_W+1)'(1) << expo;
  end

  always_comb begin
    first  = lo;
    last   = hi_eff;
    stride = (ADDR_W+1)'(1);
    unique case (kind_e)
      KIND_FULL: begin
        first = '0;
        last  = TOP_ADDR;
      end
      KIND_WINDOW: ;
      KIND_SINGLE: begin
        first = pick;
        last  = pick;
      end
      KIND_DECIM: stride = decim_stride;
      default: ;
    endcase
  end
endmodule

// File: rtl/scan_addr_counter.sv
// Holds the scan state and steps the address by the captured stride.
module scan_addr_counter #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic [ADDR_W:0]   stride,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              at_end
);
  logic              busy_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic [ADDR_W:0]   stride_q;
  logic [ADDR_W:0]   next_sum;

  assign next_sum = {1'b0, addr_q} + stride_q;
  assign at_end   = busy_q && (next_sum > {1'b0, last_q});
  assign addr     = addr_q;
  assign busy     = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      addr_q   <= '0;
      last_q   <= '0;
      stride_q <= (ADDR_W+1)'(1);
    end else if (!busy_q) begin
      if (start) begin
        busy_q   <= 1'b1;
        addr_q   <= first;
        last_q   <= last;
        stride_q <= stride;
      end
    end else if (step) begin
      if (at_end) busy_q <= 1'b0;
      else        addr_q <= next_sum[ADDR_W-1:0];
    end
  end

  // R2 / R10: an idle start lands on the resolved first line.
  p_start_loads_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && start) |=> (busy_q && addr_q == $past(first)));

  // R2: start during a scan leaves the address untouched.
  p_start_ignored_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start && !step) |=> (busy_q && $stable(addr_q)));

  // R9: no step, no motion.
  p_hold_without_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step) |=> $stable(addr_q));

  // R9: an idle step without start keeps the block idle.
  p_idle_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && step && !start) |=> !busy_q);

  // R7: a step that is not the last one advances by the stride.
  p_stride_advance_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && step && !at_end) |=>
      ({1'b0, addr_q} == {1'b0, $past(addr_q)} + $past(stride_q)));

  // R8: stepping off the last line ends the scan.
  p_end_goes_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (at_end && step) |=> !busy_q);

  // R5: the address never passes the captured end.
  p_within_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (addr_q <= last_q));
endmodule

// File: rtl/line_select_decoder.sv
// Binary address to one-hot select, gated by enable.
module line_select_decoder #(
  parameter int ADDR_W = 8,
  localparam int LINES = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [LINES-1:0]  sel
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign sel[i] = en && (addr == ADDR_W'(i));
  end
endmodule

// File: rtl/scan_line_sequencer.sv
module scan_line_sequencer #(
  parameter int ADDR_W = 8,
  localparam int LINES = 1 << ADDR_W,
  localparam int EXP_W = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [1:0]        scan_kind,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  logic [ADDR_W-1:0] pick_addr,
  input  logic [EXP_W-1:0]  decim_exp,
  output logic [LINES-1:0]  sel,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              eos
);
  logic [ADDR_W-1:0] first_w;
  logic [ADDR_W-1:0] last_w;
  logic [ADDR_W:0]   stride_w;

  scan_bounds_resolve #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) u_bounds (
    .kind   (scan_kind),
    .lo     (win_lo),
    .hi     (win_hi),
    .pick   (pick_addr),
    .expo   (decim_exp),
    .first  (first_w),
    .last   (last_w),
    .stride (stride_w)
  );

  scan_addr_counter #(.ADDR_W(ADDR_W)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .step   (step),
    .first  (first_w),
    .last   (last_w),
    .stride (stride_w),
    .addr   (addr),
    .busy   (busy),
    .at_end (eos)
  );

  line_select_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .en   (busy),
    .addr (addr),
    .sel  (sel)
  );

  // R3: one select while busy, at the reported address.
  p_onehot_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones(sel) == 1 && sel[addr]));

  // R3: nothing selected while idle.
  p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sel == '0));

  // R8: end of scan only shows while a line is selected.
  p_eos_needs_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eos |-> $onehot0(sel) && busy);
endmodule

// File: tb/scan_line_sequencer_test.sv
`timescale 1ns/1ps
module scan_line_sequencer_test;
  localparam int AW = 4;
  localparam int NL = 16;
  localparam int EW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          step = 1'b0;
  logic [1:0]    scan_kind = 2'd0;
  logic [AW-1:0] win_lo = '0;
  logic [AW-1:0] win_hi = '0;
  logic [AW-1:0] pick_addr = '0;
  logic [EW-1:0] decim_exp = '0;
  logic [NL-1:0] sel;
  logic [AW-1:0] addr;
  logic          busy;
  logic          eos;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  scan_line_sequencer #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .step(step),
    .scan_kind(scan_kind), .win_lo(win_lo), .win_hi(win_hi),
    .pick_addr(pick_addr), .decim_exp(decim_exp),
    .sel(sel), .addr(addr), .busy(busy), .eos(eos)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk(busy == 1'b0, {req, " busy"}, int'(busy), 0);
    chk(sel == '0, {req, " sel"}, int'(sel), 0);
    chk(eos == 1'b0, {req, " eos"}, int'(eos), 0);
  endtask

  task automatic chk_line(string req, int a, bit e);
    chk(busy == 1'b1, {req, " busy"}, int'(busy), 1);
    chk(int'(sel) == (1 << a), {req, "/R3 sel"}, int'(sel), 1 << a);
    chk(int'(addr) == a, {req, " addr"}, int'(addr), a);
    chk(eos == e, {req, "/R8 eos"}, int'(eos), int'(e));
  endtask

  // Expected bounds computed from the requirement text.
  task automatic run_scan(int k, int lo, int hi, int pk, int ex, string req);
    int first, last, stride, a;
    bit e;
    first = lo; last = (lo > hi) ? lo : hi; stride = 1;
    case (k)
      0: begin first = 0; last = NL - 1; end
      2: begin first = pk; last = pk; end
      3: stride = 1 << ex;
      default: ;
    endcase
    @(negedge clk);
    scan_kind = 2'(k); win_lo = AW'(lo); win_hi = AW'(hi);
    pick_addr = AW'(pk); decim_exp = EW'(ex); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2: scramble settings after capture.
    scan_kind = ~scan_kind; win_lo = ~win_lo; win_hi = win_hi + 4'd5;
    pick_addr = pick_addr + 4'd3; decim_exp = ~decim_exp;
    a = first;
    forever begin
      e = (a + stride > last);
      chk_line(req, a, e);
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      if (e) break;
      a += stride;
    end
    chk_idle({req, "/R8 after end"});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    chk(addr == '0, "R1 addr", int'(addr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after release");

    // R9: idle steps do nothing.
    step = 1'b1;
    repeat (3) @(negedge clk);
    step = 1'b0;
    chk_idle("R9 idle step");

    run_scan(0, 0, 0, 0, 0, "R4 full");

    for (int lo = 0; lo < NL; lo++)
      for (int hi = 0; hi < NL; hi++)
        run_scan(1, lo, hi, 0, 0, "R5 window");

    for (int p = 0; p < NL; p++)
      run_scan(2, 0, 0, p, 0, "R6 single");

    for (int ex = 0; ex < 4; ex++)
      for (int lo = 0; lo < NL; lo++)
        for (int hi = 0; hi < NL; hi++)
          run_scan(3, lo, hi, 0, ex, "R7 decimated");

    // R2: start while busy is ignored; R9: hold without step.
    @(negedge clk);
    scan_kind = 2'd1; win_lo = 4'd2; win_hi = 4'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    step = 1'b1; repeat (2) @(negedge clk); step = 1'b0;
    chk_line("R2 pre", 4, 1'b0);
    scan_kind = 2'd2; pick_addr = 4'd13; win_lo = 4'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_line("R2 start while busy", 4, 1'b0);
    repeat (3) @(negedge clk);
    chk_line("R9 hold", 4, 1'b0);
    for (int a = 4; a <= 9; a++) begin
      chk_line("R2 original bounds", a, a == 9);
      step = 1'b1; @(negedge clk); step = 1'b0;
    end
    chk_idle("R2 end");

    // R10: start and step together from idle.
    scan_kind = 2'd1; win_lo = 4'd5; win_hi = 4'd7; start = 1'b1; step = 1'b1;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    chk_line("R10 start wins", 5, 1'b0);
    for (int a = 5; a <= 7; a++) begin
      step = 1'b1; @(negedge clk); step = 1'b0;
    end
    chk_idle("R10 end");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL R8 watchdog actual=200000 expected=fewer cycles");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule